// File: doc/BRIEF.md
# Page Write Buffer with Timed Write Cycle

This block sits behind the serial protocol engine of a two-wire nonvolatile memory. During a write transfer it collects the data bytes into a one-page buffer. The slot pointer starts at the in-page part of the loaded address, and each received byte advances only the low bits of that pointer. Bytes past the end of the page therefore go back to the start of the same page and replace what arrived earlier in that transfer. A flag on each slot records which slots were filled.

When the stop strobe arrives, the block checks two things: at least one byte must have been buffered, and the write-protect input must be low. If both hold, it scans the page slot by slot and drives a memory write for every filled slot. It then runs a fixed timed interval whose length is a clock-cycle parameter. From the cycle after the stop until the interval ends, `busy_o` is high. The protocol engine uses it to withhold acknowledges, and the block ignores every strobe during that time. With write protect high, bytes are still accepted but nothing reaches the array and no busy period begins.

Top module: `page_write_ctrl`

## Requirements
- R1: After synchronous active-low reset, `busy_o` and `mem_we_o` are low.
- R2: `addr_i` is split into a page number (bits ADDR_W-1..PAGE_W) and an in-page slot (bits PAGE_W-1..0). A loaded address selects the slot for the next byte, and the page number of every committed byte equals the loaded page number.
- R3: Each byte advances only the slot bits. After slot 2^PAGE_W-1 comes slot 0 of the same page, and a later byte to a slot overwrites the earlier one.
- R4: Only slots that received a byte are written. All other array locations keep their contents.
- R5: A stop strobe with no buffered byte leaves `busy_o` low and writes nothing.
- R6: A stop strobe while `wp_i` is 1 writes nothing and leaves `busy_o` low.
- R7: The commit begins in the cycle after the accepted stop and covers slots 0 to 2^PAGE_W-1, one per cycle in ascending order. `mem_we_o` is high exactly in the cycles of filled slots, with `mem_addr_o` = {page, slot} and `mem_wdata_o` = that slot's byte.
- R8: `busy_o` rises in the cycle after an accepted stop and stays high for exactly 2^PAGE_W + WR_CYCLES cycles.
- R9: While `busy_o` is high, the start, address-load, byte and stop strobes are ignored.
- R10: A start strobe clears all slot-filled flags, so bytes from an unfinished earlier transfer are not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-condition strobe |
| addr_load_i | input | 1 | Load strobe for `addr_i` |
| addr_i | input | ADDR_W | Start address of the write (page, slot) |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop-condition strobe |
| wp_i | input | 1 | Write protect, 1 blocks commits |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Timed write cycle in progress |

## Verification
The bench drives the following patterns:
- A single byte write. It shows the slot and page split of the address and the exact busy length.
- A transfer that starts two slots before the page end and carries more bytes than a page holds. It separates in-page wrapping from a carry into the next page and from keeping the first byte to a slot.
- A two-byte partial write. It tells apart writing only filled slots from writing the whole page.
- An empty stop and a stop under write protect. They show that neither starts a cycle.
- A transfer sent while the block is busy. It must leave no trace in the array.
- A transfer abandoned by a new start. Its bytes must vanish, which tells flag clearing apart from flags that persist.

A behavioural model predicts every cycle's busy level, write strobe, address and data.

// File: rtl/pwb_pkg.sv
// Package: shared types of the page write buffer.
package pwb_pkg;
    // Phases of the commit sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COMMIT = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pwb_page_buf.sv
// Module: pwb_page_buf
// Holds one page of write data with a filled flag per slot. The slot pointer
// advances only within the page. Assumes its strobes are already gated by the
// caller while a write cycle runs; clr_i and wr_i may coincide (clear first).
module pwb_page_buf #(
    parameter int PAGE_W = 4,
    parameter int BASE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     load_i,
    input  logic [BASE_W+PAGE_W-1:0] addr_i,
    input  logic                     wr_i,
    input  logic [DATA_W-1:0]        data_i,
    input  logic [PAGE_W-1:0]        rd_slot_i,
    output logic [BASE_W-1:0]        base_o,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     rd_valid_o,
    output logic                     any_valid_o
);
    localparam int PAGE_N = 1 << PAGE_W;

    logic [DATA_W-1:0] data_q [PAGE_N];
    logic [PAGE_N-1:0] valid_q;
    logic [PAGE_W-1:0] ptr_q;
    logic [BASE_W-1:0] base_q;

    // Purpose: track page number, slot pointer and filled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            base_q  <= '0;
        end else begin
            if (clr_i)  valid_q <= '0;
            if (load_i) begin
                base_q <= addr_i[BASE_W+PAGE_W-1:PAGE_W];
                ptr_q  <= addr_i[PAGE_W-1:0];
            end
            if (wr_i) begin
                valid_q[ptr_q] <= 1'b1;
                ptr_q          <= ptr_q + 1'b1;
            end
        end
    end

    // Purpose: store the byte in the slot the pointer selects.
    always_ff @(posedge clk) begin
        if (wr_i) data_q[ptr_q] <= data_i;
    end

    assign base_o      = base_q;
    assign rd_data_o   = data_q[rd_slot_i];
    assign rd_valid_o  = valid_q[rd_slot_i];
    assign any_valid_o = |valid_q;

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !load_i) |=> (base_o == $past(base_o))); // R3
endmodule

// File: rtl/pwb_wr_seq.sv
// Module: pwb_wr_seq
// Sequences the commit: from an accepted stop it scans every slot, one per
// cycle, then counts WR_CYCLES cycles. Busy covers both phases. Assumes
// WR_CYCLES >= 1 and that go_i already folds in data presence and protect.
module pwb_wr_seq
    import pwb_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              go_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic              done_o,
    output logic [PAGE_W-1:0] slot_o
);
    localparam int                CNT_W     = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(WR_CYCLES - 1);
    localparam logic [PAGE_W-1:0] SLOT_LAST = '1;

    seq_state_t        state_q;
    logic [PAGE_W-1:0] slot_q;
    logic [CNT_W-1:0]  cnt_q;

    // Purpose: advance through idle, slot scan and timed wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (stop_i && go_i) begin
                        state_q <= SEQ_COMMIT;
                        slot_q  <= '0;
                    end
                end
                SEQ_COMMIT: begin
                    if (slot_q == SLOT_LAST) begin
                        state_q <= SEQ_WAIT;
                        cnt_q   <= '0;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (cnt_q == CNT_LAST) state_q <= SEQ_IDLE;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != SEQ_IDLE);
    assign commit_o = (state_q == SEQ_COMMIT);
    assign done_o   = commit_o && (slot_q == SLOT_LAST);
    assign slot_o   = slot_q;

    AST_COMMIT_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && go_i) |=> (commit_o && slot_o == '0)); // R8
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && $past(commit_o)) |-> (slot_o == $past(slot_o) + 1'b1)); // R7
    AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(stop_i && go_i)) |=> !busy_o); // R5
endmodule

// File: rtl/page_write_ctrl.sv
// Module: page_write_ctrl
// Page write buffer and timed write controller. Collects write bytes, commits
// the filled slots at stop unless protected, then holds busy for a fixed
// interval. Assumes one strobe per cycle from the protocol engine.
module page_write_ctrl #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic              busy, commit, done, any_valid, rd_valid;
    logic [PAGE_W-1:0] slot;
    logic [BASE_W-1:0] base;
    logic [DATA_W-1:0] rd_data;
    logic              buf_clr, buf_load, buf_wr, seq_stop, seq_go;

    // Purpose: drop every strobe while the write cycle runs.
    always_comb begin
        buf_clr  = (start_i && !busy) || done;
        buf_load = addr_load_i && !busy;
        buf_wr   = byte_vld_i && !busy;
        seq_stop = stop_i && !busy;
        seq_go   = any_valid && !wp_i;
    end

    pwb_page_buf #(.PAGE_W(PAGE_W), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .load_i(buf_load),
        .addr_i(addr_i), .wr_i(buf_wr), .data_i(byte_i), .rd_slot_i(slot),
        .base_o(base), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .any_valid_o(any_valid)
    );

    pwb_wr_seq #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .stop_i(seq_stop), .go_i(seq_go),
        .busy_o(busy), .commit_o(commit), .done_o(done), .slot_o(slot)
    );

    assign mem_we_o    = commit && rd_valid;
    assign mem_addr_o  = {base, slot};
    assign mem_wdata_o = rd_data;
    assign busy_o      = busy;

    AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o); // R6
    AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
        (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W]))); // R9
    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R7
endmodule

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;
    localparam int ADDR_W = 10, PAGE_W = 4, DATA_W = 8, WR_CYCLES = 40;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int MEM_N  = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, addr_load_i = 0, byte_vld_i = 0, stop_i = 0, wp_i = 0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] byte_i = '0;
    logic mem_we_o, busy_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                      .WR_CYCLES(WR_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
        .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
        .wp_i(wp_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .busy_o(busy_o)
    );

    // Array seen by the design, and the array the requirements predict.
    logic [7:0] tbmem  [MEM_N];
    logic [7:0] golden [MEM_N];

    // Behavioural model state.
    int   m_commit = -1, m_wait = 0, m_base = 0, m_ptr = 0;
    bit   m_valid [PAGE_N];
    logic [7:0] m_buf [PAGE_N];

    function automatic logic [7:0] initv(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic bit m_any();
        foreach (m_valid[i]) if (m_valid[i]) return 1;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model: advance one clock from the strobes seen at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_commit = -1; m_wait = 0; m_base = 0; m_ptr = 0;
            foreach (m_valid[i]) m_valid[i] = 0;
        end else if (m_commit >= 0) begin
            m_commit++;
            if (m_commit == PAGE_N) begin
                m_commit = -1; m_wait = WR_CYCLES;
                foreach (m_valid[i]) m_valid[i] = 0;
            end
        end else if (m_wait > 0) begin
            m_wait--;
        end else begin
            if (start_i) foreach (m_valid[i]) m_valid[i] = 0;
            if (addr_load_i) begin
                m_base = int'(addr_i) / PAGE_N;
                m_ptr  = int'(addr_i) % PAGE_N;
            end
            if (byte_vld_i) begin
                m_buf[m_ptr] = byte_i; m_valid[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % PAGE_N;
            end
            if (stop_i && m_any() && !wp_i) m_commit = 0;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        bit exp_busy, exp_we;
        exp_busy = (m_commit >= 0) || (m_wait > 0);
        exp_we   = (m_commit >= 0) && m_valid[m_commit];
        check(busy_o == exp_busy, "R8 busy", int'(busy_o), int'(exp_busy));
        check(mem_we_o == exp_we, "R7 we", int'(mem_we_o), int'(exp_we));
        if (exp_we) begin
            check(int'(mem_addr_o) == m_base * PAGE_N + m_commit, "R7 addr",
                  int'(mem_addr_o), m_base * PAGE_N + m_commit);
            check(mem_wdata_o == m_buf[m_commit], "R7 data",
                  int'(mem_wdata_o), int'(m_buf[m_commit]));
            golden[m_base * PAGE_N + m_commit] = m_buf[m_commit];
        end
        if (mem_we_o) tbmem[mem_addr_o] = mem_wdata_o;
    end

    task automatic pulse_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask
    task automatic load(int a);
        addr_load_i = 1; addr_i = ADDR_W'(a); @(negedge clk); addr_load_i = 0;
    endtask
    task automatic send(int b);
        byte_vld_i = 1; byte_i = DATA_W'(b); @(negedge clk); byte_vld_i = 0;
    endtask
    task automatic pulse_stop();
        stop_i = 1; @(negedge clk); stop_i = 0;
    endtask
    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
    endtask
    task automatic mem_is(int a, int exp, string req);
        check(tbmem[a] == 8'(exp), req, int'(tbmem[a]), exp);
        check(tbmem[a] == golden[a], req, int'(tbmem[a]), int'(golden[a]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < MEM_N; i++) begin tbmem[i] = initv(i); golden[i] = initv(i); end
        repeat (3) @(negedge clk);
        check(busy_o == 0, "R1 busy", int'(busy_o), 0);
        check(mem_we_o == 0, "R1 we", int'(mem_we_o), 0);
        rst_n = 1; @(negedge clk);

        // Single byte: page 0x12, slot 3; busy length.
        pulse_start(); load('h123); send('h5C); pulse_stop();
        wait_idle(n);
        check(n == PAGE_N + WR_CYCLES, "R8 length", n, PAGE_N + WR_CYCLES);
        mem_is('h123, 'h5C, "R2 slot");
        mem_is('h124, initv('h124), "R4 neighbour");

        // Eighteen bytes from slot 14: wrap within page 0x23.
        pulse_start(); load('h23E);
        for (int k = 0; k < 18; k++) send('h10 + k);
        pulse_stop(); wait_idle(n);
        mem_is('h23E, 'h20, "R3 overwrite");
        mem_is('h23F, 'h21, "R3 overwrite");
        mem_is('h230, 'h12, "R3 wrap");
        mem_is('h23D, 'h1F, "R3 wrap");
        mem_is('h240, initv('h240), "R2 next page");

        // Partial page: two bytes.
        pulse_start(); load('h305); send('hAA); send('hBB); pulse_stop(); wait_idle(n);
        mem_is('h305, 'hAA, "R4 partial");
        mem_is('h306, 'hBB, "R4 partial");
        mem_is('h304, initv('h304), "R4 untouched");
        mem_is('h307, initv('h307), "R4 untouched");

        // Stop with no data.
        pulse_start(); load('h100); pulse_stop();
        repeat (3) begin check(busy_o == 0, "R5 no cycle", int'(busy_o), 0); @(negedge clk); end

        // Write protect.
        wp_i = 1;
        pulse_start(); load('h050); send('h77); pulse_stop();
        check(busy_o == 0, "R6 no busy", int'(busy_o), 0);
        repeat (PAGE_N + 2) @(negedge clk);
        mem_is('h050, initv('h050), "R6 protected");
        wp_i = 0;

        // Strobes while busy are ignored.
        pulse_start(); load('h3A0); send('h11); pulse_stop();
        check(busy_o == 1, "R8 rise", int'(busy_o), 1);
        pulse_start(); load('h0F0); send('h99); pulse_stop();
        wait_idle(n);
        repeat (3) begin check(busy_o == 0, "R9 no second cycle", int'(busy_o), 0); @(negedge clk); end
        mem_is('h3A0, 'h11, "R9 first kept");
        mem_is('h0F0, initv('h0F0), "R9 ignored");
        mem_is('h3A1, initv('h3A1), "R9 page slot");

        // Start discards an unfinished transfer.
        pulse_start(); load('h200); send('hE1); send('hE2);
        pulse_start(); load('h205); send('hE5); pulse_stop(); wait_idle(n);
        mem_is('h200, initv('h200), "R10 dropped");
        mem_is('h201, initv('h201), "R10 dropped");
        mem_is('h205, 'hE5, "R10 kept");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule